// File: doc/BRIEF.md
# Pipelined Table-Driven Multiplier Modulo 65537

This block multiplies a 16-bit operand by a 16-bit constant modulo 2^16+1 and produces one result per clock. Both operands follow the convention where the all-zero word stands for 2^16, so every 16-bit word maps onto a nonzero residue and the multiplication is invertible. It is meant as one multiplier inside a deeply pipelined block-cipher datapath, where each multiplier holds a round sub-key that changes rarely compared with the data.

The constant is not fed to a hardware multiplier. It is folded into four 16-row tables, one per nibble of the operand, whose rows hold the nibble value times the constant as 20-bit entries. Loading a new constant rewrites every row of all four tables in one cycle. The four looked-up partial products are shifted and summed into a 32-bit product, which is then reduced as low half minus high half, with 2^16+1 added back when the difference is negative. A flag for the zero-coded cases travels with the data and picks a precomputed result at the end.

The pipeline has six register stages. Results emerge six cycles after the operand is presented, and the output word holds its last value while no result is valid.

Top module: `kmul_mod_pipe`

## Requirements
- R1: During and right after reset, out_valid is 0 and out_data is 0, and the constant is 1, so an operand sent before any load returns unchanged.
- R2: For a valid operand x and constant K, both in 1..65535, out_data equals (x*K) mod 65537.
- R3: An operand of 0 (standing for 65536) yields (65537 - K) mod 65537, where a constant of 0 counts as 65536.
- R4: A constant of 0 (standing for 65536) with a nonzero operand x yields 65537 - x.
- R5: An operand of 0 with a constant of 0 yields 1.
- R6: A result whose residue is 65536 is output as the word 0 (for example x=2, K=0x8000).
- R7: out_valid is asserted exactly six cycles after in_valid, and operands presented on consecutive cycles give results on consecutive cycles in the same order.
- R8: An operand presented in the same cycle as load_en uses the previous constant; operands presented in later cycles use the new one; operands already in flight are unaffected.
- R9: While out_valid is low, out_data holds the value of the last result.
- R10: in_data is ignored while in_valid is low: no result is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Replace the constant with load_const at this edge |
| load_const | input | 16 | New constant, 0 meaning 65536 |
| in_valid | input | 1 | in_data carries an operand this cycle |
| in_data | input | 16 | Operand, 0 meaning 65536 |
| out_valid | output | 1 | out_data carries a result this cycle |
| out_data | output | 16 | Product modulo 65537, 65536 coded as 0 |

## Verification
The operand stream is tried with random nonzero operands against random constants, which separates a correct nibble alignment and carry chain from a shifted or truncated one, and with operands near 65535, whose products push the high half above the low half and so exercise the negative-difference correction. The zero-coded cases (operand 0, constant 0, both 0) and the product landing on 65536 are sent singly, because each takes a different arm of the final selector. A constant load placed in the middle of a back-to-back burst, on the same cycle as one operand, tells apart a table rewrite that takes effect one cycle early or late, and idle gaps with changing in_data show whether invalid operands leak through or the output word drifts.

// File: rtl/kmul_pkg.sv
package kmul_pkg;

    // Word and table geometry; the summing tree assumes four nibble lanes.
    localparam int KW     = 16;
    localparam int NW     = 4;
    localparam int NLANES = KW / NW;
    localparam int ROWS   = 1 << NW;
    localparam int EW     = KW + NW;
    localparam int HW     = EW + NW;
    localparam int PW     = 2 * KW;
    localparam int DW     = KW + 1;

    localparam logic [DW-1:0] MODV    = {1'b1, {(KW-1){1'b0}}, 1'b1};
    localparam logic [DW-1:0] TWO_KW  = {1'b1, {KW{1'b0}}};
    localparam logic [KW-1:0] RESET_K = KW'(1);

    typedef logic [KW-1:0] word_t;
    typedef logic [EW-1:0] ent_t;

    // Side information carried beside the datapath through every stage.
    typedef struct packed {
        logic  valid;
        logic  spec;
        word_t spec_val;
    } tag_t;

    function automatic ent_t row_product(input logic [NW-1:0] r, input word_t k);
        return ent_t'(r) * ent_t'(k);
    endfunction

    // Result when either factor is the zero code (65536): 65537 minus the other.
    function automatic word_t spec_result(input word_t x, input word_t k);
        logic [DW-1:0] other;
        if (x == '0)
            other = (k == '0) ? TWO_KW : {1'b0, k};
        else
            other = {1'b0, x};
        return KW'(MODV - other);
    endfunction

endpackage

// File: rtl/kmul_lut.sv
module kmul_lut
    import kmul_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  word_t         wr_const,
    input  logic [NW-1:0] rd_nib,
    output ent_t          rd_data
);

    ent_t mem [ROWS];

    // Whole-table rewrite models reconfiguring the lookup contents.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < ROWS; r++)
                mem[r] <= row_product(NW'(r), RESET_K);
        end else if (wr_en) begin
            for (int r = 0; r < ROWS; r++)
                mem[r] <= row_product(NW'(r), wr_const);
        end
    end

    assign rd_data = mem[rd_nib];

endmodule

// File: rtl/kmul_sum.sv
module kmul_sum
    import kmul_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  tag_t                       in_tag,
    input  logic [NLANES-1:0][EW-1:0]  in_pp,
    output tag_t                       out_tag,
    output logic [PW-1:0]              out_prod
);

    tag_t          t2;
    logic [HW-1:0] lo2;
    logic [HW-1:0] hi2;

    // Stage 2: pairwise sums of neighbouring nibble lanes.
    always_ff @(posedge clk) begin
        if (rst) t2 <= '0;
        else     t2 <= in_tag;
    end

    always_ff @(posedge clk) begin
        lo2 <= HW'(in_pp[0]) + {in_pp[1], {NW{1'b0}}};
        hi2 <= HW'(in_pp[2]) + {in_pp[3], {NW{1'b0}}};
    end

    // Stage 3: final wide sum into the full product.
    always_ff @(posedge clk) begin
        if (rst) out_tag <= '0;
        else     out_tag <= t2;
    end

    always_ff @(posedge clk) begin
        out_prod <= PW'(lo2) + {hi2, {(2*NW){1'b0}}};
    end

endmodule

// File: rtl/kmul_reduce.sv
module kmul_reduce
    import kmul_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  tag_t          in_tag,
    input  logic [PW-1:0] in_prod,
    output logic          out_valid,
    output word_t         out_data
);

    tag_t          t4;
    tag_t          t5;
    logic [DW:0]   diff4;
    logic [DW-1:0] res5;

    // Stage 4: low half minus high half, with a sign bit.
    always_ff @(posedge clk) begin
        if (rst) t4 <= '0;
        else     t4 <= in_tag;
    end

    always_ff @(posedge clk) begin
        diff4 <= {2'b00, in_prod[KW-1:0]} - {2'b00, in_prod[PW-1:KW]};
    end

    // Stage 5: compare sign and add the modulus back when negative.
    always_ff @(posedge clk) begin
        if (rst) t5 <= '0;
        else     t5 <= t4;
    end

    always_ff @(posedge clk) begin
        if (diff4[DW])
            res5 <= DW'(diff4 + {1'b0, MODV});
        else
            res5 <= diff4[DW-1:0];
    end

    // Stage 6: select special-case or reduced value, code 65536 as 0.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= t5.valid;
            if (t5.valid) begin
                if (t5.spec)
                    out_data <= t5.spec_val;
                else if (res5 == TWO_KW)
                    out_data <= '0;
                else
                    out_data <= res5[KW-1:0];
            end
        end
    end

endmodule

// File: rtl/kmul_mod_pipe.sv
module kmul_mod_pipe
    import kmul_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load_en,
    input  logic [15:0] load_const,
    input  logic        in_valid,
    input  logic [15:0] in_data,
    output logic        out_valid,
    output logic [15:0] out_data
);

    word_t                      k_q;
    logic [NLANES-1:0][EW-1:0]  lut_rd;
    logic [NLANES-1:0][EW-1:0]  pp1;
    tag_t                       tag1;
    tag_t                       tag3;
    logic [PW-1:0]              prod3;

    // Current constant, kept for the zero-code special case.
    always_ff @(posedge clk) begin
        if (rst)          k_q <= RESET_K;
        else if (load_en) k_q <= load_const;
    end

    for (genvar g = 0; g < NLANES; g++) begin : g_lane
        kmul_lut u_lut (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (load_en),
            .wr_const (load_const),
            .rd_nib   (in_data[g*NW +: NW]),
            .rd_data  (lut_rd[g])
        );
    end

    // Stage 1: table lookup and zero-code detection.
    always_ff @(posedge clk) begin
        if (rst)
            tag1 <= '0;
        else
            tag1 <= '{valid:    in_valid,
                      spec:     (in_data == '0) || (k_q == '0),
                      spec_val: spec_result(in_data, k_q)};
    end

    always_ff @(posedge clk) begin
        pp1 <= lut_rd;
    end

    kmul_sum u_sum (
        .clk      (clk),
        .rst      (rst),
        .in_tag   (tag1),
        .in_pp    (pp1),
        .out_tag  (tag3),
        .out_prod (prod3)
    );

    kmul_reduce u_red (
        .clk       (clk),
        .rst       (rst),
        .in_tag    (tag3),
        .in_prod   (prod3),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

endmodule

// File: rtl/kmul_chk.sv
module kmul_chk
    import kmul_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        load_en,
    input logic [15:0] load_const,
    input logic        in_valid,
    input logic [15:0] in_data,
    input logic        out_valid,
    input logic [15:0] out_data
);

    localparam int LAT = 6;

    logic [2:0] cnt;
    word_t      k_shadow;
    word_t      x_pipe [LAT];
    word_t      k_pipe [LAT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            k_shadow <= RESET_K;
        end else begin
            if (cnt != 3'(LAT)) cnt <= cnt + 3'd1;
            if (load_en) k_shadow <= load_const;
        end
    end

    always_ff @(posedge clk) begin
        x_pipe[0] <= in_data;
        k_pipe[0] <= k_shadow;
        for (int i = 1; i < LAT; i++) begin
            x_pipe[i] <= x_pipe[i-1];
            k_pipe[i] <= k_pipe[i-1];
        end
    end

    // R1: reset clears the output side
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    // R7: fixed six-cycle latency
    assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt == 3'(LAT)) |-> (out_valid == $past(in_valid, 6)));

    // R9: output word holds between results
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (cnt != 3'd0 && !out_valid) |-> $stable(out_data));

    // R2: unit operand returns the constant, unit constant returns the operand
    assert_unit_operand_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && x_pipe[LAT-1] == 16'd1) |-> (out_data == k_pipe[LAT-1]));

    assert_unit_const_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && k_pipe[LAT-1] == 16'd1) |-> (out_data == x_pipe[LAT-1]));

    // R3: zero-coded operand
    assert_zero_operand_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && x_pipe[LAT-1] == '0) |->
        (out_data == KW'(17'h10001 - ((k_pipe[LAT-1] == '0) ? 17'h10000 : {1'b0, k_pipe[LAT-1]}))));

    // R4: zero-coded constant
    assert_zero_const_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && k_pipe[LAT-1] == '0 && x_pipe[LAT-1] != '0) |->
        (out_data == KW'(17'h10001 - {1'b0, x_pipe[LAT-1]})));

endmodule

bind kmul_mod_pipe kmul_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_en    (load_en),
    .load_const (load_const),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_data   (out_data)
);

// File: tb/test_kmul_mod_pipe.sv
module test_kmul_mod_pipe;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic [15:0] load_const = '0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_data;

    always #4 clk = ~clk;

    kmul_mod_pipe i_kmul_mod_pipe (
        .clk        (clk),
        .rst        (rst),
        .load_en    (load_en),
        .load_const (load_const),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    int          n_checks = 0;
    int          n_fails  = 0;
    int          cyc      = 0;
    logic [15:0] k_model  = 16'd1;
    logic [15:0] last_out = '0;
    logic [15:0] exp_q[$];
    int          stamp_q[$];
    string       req_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] ref_mul(input logic [15:0] x, input logic [15:0] k);
        longint a, b, r;
        a = (x == 0) ? 65536 : longint'(x);
        b = (k == 0) ? 65536 : longint'(k);
        r = (a * b) % 65537;
        return (r == 65536) ? 16'd0 : 16'(r);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    // Driver: one operand per call, optional constant load in the same cycle.
    task automatic send(input logic [15:0] x, input bit ld, input logic [15:0] nk, input string req);
        @(negedge clk);
        in_valid   = 1'b1;
        in_data    = x;
        load_en    = ld;
        load_const = nk;
        exp_q.push_back(ref_mul(x, k_model));
        stamp_q.push_back(cyc);
        req_q.push_back(req);
        if (ld) k_model = nk;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            load_en  = 1'b0;
            in_data  = 16'(i * 977 + 13);
        end
    endtask

    task automatic load(input logic [15:0] k);
        @(negedge clk);
        in_valid   = 1'b0;
        load_en    = 1'b1;
        load_const = k;
        k_model    = k;
    endtask

    // Monitor: pops the scoreboard as results appear.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected result", 1, 0);
            end else begin
                string r;
                int    st;
                logic [15:0] e;
                e  = exp_q.pop_front();
                st = stamp_q.pop_front();
                r  = req_q.pop_front();
                check(r, out_data, e);
                check("R7 latency", cyc - st, 6);
            end
            last_out = out_data;
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            n_fails++;
            $display("FAIL watchdog: actual cycle %0d expected below 20000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 out_valid in reset", out_valid, 0);
        check("R1 out_data in reset", out_data, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid after reset", out_valid, 0);
        check("R1 out_data after reset", out_data, 0);
        send(16'd1234, 1'b0, '0, "R1 default constant");
        send(16'd0, 1'b0, '0, "R1 zero operand, default constant");
        idle(8);

        // R2 and R7: random back-to-back operands under random constants
        for (int c = 0; c < 4; c++) begin
            load(16'($urandom_range(1, 65535)));
            for (int i = 0; i < 24; i++)
                send(16'($urandom_range(1, 65535)), 1'b0, '0, "R2 random product");
        end
        // R2: large operands stress the negative-difference correction
        load(16'hFFFF);
        send(16'hFFFF, 1'b0, '0, "R2 max times max");
        send(16'hFFFE, 1'b0, '0, "R2 near max");
        send(16'd1, 1'b0, '0, "R2 unit operand");
        idle(8);

        // R3: zero operand
        load(16'd5);
        send(16'd0, 1'b0, '0, "R3 zero operand K=5");
        load(16'hFFFF);
        send(16'd0, 1'b0, '0, "R3 zero operand K=65535");
        // R4: zero constant
        load(16'd0);
        send(16'd7, 1'b0, '0, "R4 zero constant x=7");
        send(16'd1, 1'b0, '0, "R4 zero constant x=1");
        // R5: both zero
        send(16'd0, 1'b0, '0, "R5 both zero");
        // R6: residue 65536 coded as 0
        load(16'h8000);
        send(16'd2, 1'b0, '0, "R6 residue 65536");
        idle(8);

        // R8: load in the middle of a burst
        load(16'd3);
        send(16'd100, 1'b0, '0, "R8 before load");
        send(16'd200, 1'b0, '0, "R8 before load");
        send(16'd300, 1'b1, 16'd11, "R8 same-cycle uses old constant");
        send(16'd400, 1'b0, '0, "R8 after load");
        send(16'd500, 1'b0, '0, "R8 after load");
        idle(10);

        // R9: output holds the last result; R10: idle operands give nothing
        check("R9 hold last result", out_data, last_out);
        idle(12);
        check("R10 no output while idle", out_valid, 0);
        check("R9 hold after idle", out_data, last_out);
        check("R10 scoreboard drained", exp_q.size(), 0);

        summary();
        $finish;
    end

endmodule